// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit executes the shift group of a 64-bit integer pipeline. On an issue strobe it takes a raw 32-bit instruction word together with a 64-bit source operand and a 64-bit amount operand. It works out which shift or rotate is meant, computes the 64-bit result and registers it with a one-cycle valid strobe. Encodings that fall inside the shift group but carry an undefined operation selector raise a one-cycle reserved-instruction flag instead of a result.

The group covers left logical, right logical, right arithmetic and right rotate. Each exists as a 32-bit form, whose result is sign-extended to 64 bits, and as a doubleword form. The amount comes either from the instruction or from the amount operand. Doubleword immediate forms also come in a variant that adds 32 to the amount. Words outside the group leave both strobes low, so that a neighbouring unit can claim them. Operand fetch, hazards and exception delivery belong to other units.

Top module: `shift_rot_unit`

## Requirements
- R1: While reset is asserted and after its release, result_o is zero and valid_o and resv_exc_o are low until the first issue.
- R2: An issue of a valid group member in cycle t sets valid_o with its result in cycle t+1 only. With issue_i low, both strobes are low in the next cycle and result_o keeps its value, whatever the other inputs carry.
- R3: Immediate forms take the amount from instruction bits 10:6. Register forms take the amount from amt_i: bits 4:0 for 32-bit forms and bits 5:0 for doubleword forms. All other amt_i bits are ignored.
- R4: A 32-bit left or logical right shift works on src_i[31:0] with zero fill, and bit 31 of the 32-bit outcome is copied into result bits 63:32.
- R5: A 32-bit arithmetic right shift fills with src_i[31] and sign-extends the outcome to 64 bits.
- R6: A 32-bit rotate right by n returns the ORed pair (low word shifted right by n) and (low word shifted left by 32-n), sign-extended. With n = 0 it returns the low word unchanged, sign-extended.
- R7: Doubleword shifts and rotates act on all 64 bits for amounts 0 to 63. A rotate by 0 returns src_i exactly.
- R8: The plus-32 doubleword immediate forms use 32 plus instruction bits 10:6 as the amount, which covers 32 to 63.
- R9: For right-logical immediate forms (function 0x02, 0x3A, 0x3E) the selector is instruction bits 25:21. For right-logical register forms (0x06, 0x16) the selector is bits 10:6. Selector 0 means shift, 1 means rotate, and any value from 2 to 31 is reserved.
- R10: A reserved selector raises resv_exc_o for exactly one cycle after the issue. In that cycle valid_o is low and result_o keeps its previous value.
- R11: A word whose bits 31:26 are not zero, or whose function code is not in the group, leaves valid_o and resv_exc_o low and leaves result_o unchanged.
- R12: The group requires bits 31:26 to be zero. The function codes (bits 5:0) are: 32-bit immediate left 0x00, right 0x02, arithmetic 0x03; 32-bit register left 0x04, right 0x06, arithmetic 0x07; doubleword register left 0x14, right 0x16, arithmetic 0x17; doubleword immediate left 0x38, right 0x3A, arithmetic 0x3B; plus-32 left 0x3C, right 0x3E, arithmetic 0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Raw instruction word |
| src_i | input | 64 | Operand to be shifted or rotated |
| amt_i | input | 64 | Amount operand for register forms |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | result_o was updated by the previous issue |
| resv_exc_o | output | 1 | Previous issue carried a reserved selector |

## Verification
Two things can meet in the same cycle: a result just produced and a reserved-instruction event that must not disturb it. The bench issues a valid rotate and then, on the very next edge, a word with a reserved selector. It checks that in the following cycle the exception flag is high, valid is low and result_o still equals the rotate result that the scoreboard predicted. Back-to-back valid issues are also compared against an independent reference model. These cover every selector from 2 to 31 and the amounts 0, 1, 31, 32 and 63.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2,
        SH_ROTR  = 2'd3
    } sh_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    // function codes (instruction bits 5:0)
    localparam logic [5:0] FN_W_LI  = 6'h00;
    localparam logic [5:0] FN_W_RI  = 6'h02;
    localparam logic [5:0] FN_W_AI  = 6'h03;
    localparam logic [5:0] FN_W_LR  = 6'h04;
    localparam logic [5:0] FN_W_RR  = 6'h06;
    localparam logic [5:0] FN_W_AR  = 6'h07;
    localparam logic [5:0] FN_D_LR  = 6'h14;
    localparam logic [5:0] FN_D_RR  = 6'h16;
    localparam logic [5:0] FN_D_AR  = 6'h17;
    localparam logic [5:0] FN_D_LI  = 6'h38;
    localparam logic [5:0] FN_D_RI  = 6'h3A;
    localparam logic [5:0] FN_D_AI  = 6'h3B;
    localparam logic [5:0] FN_D_LI2 = 6'h3C;
    localparam logic [5:0] FN_D_RI2 = 6'h3E;
    localparam logic [5:0] FN_D_AI2 = 6'h3F;

    localparam logic [5:0] GRP_MAJOR = 6'h00;

    typedef struct packed {
        logic   hit;      // word belongs to the shift group
        logic   bad;      // reserved selector value
        sh_op_e op;
        logic   word;     // 32-bit form
        logic   use_reg;  // amount from operand
        logic   plus32;   // amount offset by half width
    } dec_t;

endpackage

// File: rtl/shift_rot_decode.sv
module shift_rot_decode
    import shift_rot_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic [5:0] major;
    logic [5:0] fn;
    logic [4:0] sel_hi;
    logic [4:0] sel_lo;

    assign major  = instr[31:26];
    assign fn     = instr[5:0];
    assign sel_hi = instr[25:21];
    assign sel_lo = instr[10:6];

    always_comb begin
        dec         = '0;
        dec.op      = SH_LEFT;
        dec.hit     = 1'b1;
        unique case (fn)
            FN_W_LI: begin dec.word = 1'b1; dec.op = SH_LEFT;  end
            FN_W_AI: begin dec.word = 1'b1; dec.op = SH_ARITH; end
            FN_W_RI: begin
                dec.word = 1'b1;
                if (sel_hi == 5'd0)      dec.op  = SH_RIGHT;
                else if (sel_hi == 5'd1) dec.op  = SH_ROTR;
                else                     dec.bad = 1'b1;
            end
            FN_W_LR: begin dec.word = 1'b1; dec.use_reg = 1'b1; dec.op = SH_LEFT;  end
            FN_W_AR: begin dec.word = 1'b1; dec.use_reg = 1'b1; dec.op = SH_ARITH; end
            FN_W_RR: begin
                dec.word    = 1'b1;
                dec.use_reg = 1'b1;
                if (sel_lo == 5'd0)      dec.op  = SH_RIGHT;
                else if (sel_lo == 5'd1) dec.op  = SH_ROTR;
                else                     dec.bad = 1'b1;
            end
            FN_D_LR: begin dec.use_reg = 1'b1; dec.op = SH_LEFT;  end
            FN_D_AR: begin dec.use_reg = 1'b1; dec.op = SH_ARITH; end
            FN_D_RR: begin
                dec.use_reg = 1'b1;
                if (sel_lo == 5'd0)      dec.op  = SH_RIGHT;
                else if (sel_lo == 5'd1) dec.op  = SH_ROTR;
                else                     dec.bad = 1'b1;
            end
            FN_D_LI: dec.op = SH_LEFT;
            FN_D_AI: dec.op = SH_ARITH;
            FN_D_RI: begin
                if (sel_hi == 5'd0)      dec.op  = SH_RIGHT;
                else if (sel_hi == 5'd1) dec.op  = SH_ROTR;
                else                     dec.bad = 1'b1;
            end
            FN_D_LI2: begin dec.plus32 = 1'b1; dec.op = SH_LEFT;  end
            FN_D_AI2: begin dec.plus32 = 1'b1; dec.op = SH_ARITH; end
            FN_D_RI2: begin
                dec.plus32 = 1'b1;
                if (sel_hi == 5'd0)      dec.op  = SH_RIGHT;
                else if (sel_hi == 5'd1) dec.op  = SH_ROTR;
                else                     dec.bad = 1'b1;
            end
            default: dec.hit = 1'b0;
        endcase
        if (major != GRP_MAJOR) begin
            dec.hit = 1'b0;
        end
        if (!dec.hit) begin
            dec.bad = 1'b0;
        end
    end

endmodule

// File: rtl/shift_rot_barrel.sv
module shift_rot_barrel
    import shift_rot_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    input  fill_e                fill,
    output logic [W-1:0]         dout
);

    localparam int AW = $clog2(W);

    logic [AW:0][W-1:0] stage;

    assign stage[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [S-1:0] fill_bits;
        assign fill_bits = (fill == FILL_WRAP) ? stage[k][S-1:0] :
                           (fill == FILL_SIGN) ? {S{din[W-1]}}   : '0;
        assign stage[k+1] = amt[k] ? {fill_bits, stage[k][W-1:S]} : stage[k];
    end

    assign dout = stage[AW];

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
    import shift_rot_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] amt_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              resv_exc_o
);

    localparam int HALF_W = DATA_W / 2;
    localparam int AMT_W  = $clog2(DATA_W);
    localparam int HAMT_W = AMT_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              vld;
        logic              exc;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;

    logic [AMT_W-1:0]  amount;
    fill_e             fill;
    logic [DATA_W-1:0] full_in, full_out, full_res;
    logic [HALF_W-1:0] half_src, half_in, half_out, half_res;
    logic [DATA_W-1:0] op_res;

    shift_rot_decode u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    // amount selection
    always_comb begin
        if (dec.use_reg) begin
            amount = dec.word ? {1'b0, amt_i[HAMT_W-1:0]} : amt_i[AMT_W-1:0];
        end else begin
            amount = AMT_W'(instr_i[10:6]);
            if (dec.plus32) begin
                amount = amount | AMT_W'(HALF_W);
            end
        end
    end

    always_comb begin
        unique case (dec.op)
            SH_ARITH: fill = FILL_SIGN;
            SH_ROTR:  fill = FILL_WRAP;
            default:  fill = FILL_ZERO;
        endcase
    end

    // left shifts run through the right-shifting barrel bit-reversed
    assign half_src = src_i[HALF_W-1:0];
    assign full_in  = (dec.op == SH_LEFT) ? {<<{src_i}}    : src_i;
    assign half_in  = (dec.op == SH_LEFT) ? {<<{half_src}} : half_src;

    shift_rot_barrel #(.W(DATA_W)) u_full (
        .din  (full_in),
        .amt  (amount),
        .fill (fill),
        .dout (full_out)
    );

    shift_rot_barrel #(.W(HALF_W)) u_half (
        .din  (half_in),
        .amt  (amount[HAMT_W-1:0]),
        .fill (fill),
        .dout (half_out)
    );

    assign full_res = (dec.op == SH_LEFT) ? {<<{full_out}} : full_out;
    assign half_res = (dec.op == SH_LEFT) ? {<<{half_out}} : half_out;
    assign op_res   = dec.word ? {{HALF_W{half_res[HALF_W-1]}}, half_res} : full_res;

    // next state
    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.exc = 1'b0;
        if (issue_i && dec.hit) begin
            if (dec.bad) begin
                st_d.exc = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                st_d.res = op_res;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o   = st_q.res;
    assign valid_o    = st_q.vld;
    assign resv_exc_o = st_q.exc;

    logic unused_bits;
    assign unused_bits = ^{instr_i[20:11], amt_i[DATA_W-1:AMT_W]};

endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk
    import shift_rot_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [31:0]       instr_i,
    input logic [DATA_W-1:0] src_i,
    input logic [DATA_W-1:0] amt_i,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o,
    input logic              resv_exc_o
);

    localparam int AMT_W = $clog2(DATA_W);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !resv_exc_o && result_o == '0));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!valid_o && !resv_exc_o && $stable(result_o)));

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && resv_exc_o));

    p_exc_holds_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resv_exc_o |-> $stable(result_o));

    p_bad_selector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && instr_i[31:26] == GRP_MAJOR && instr_i[5:0] == FN_W_RI
         && instr_i[25:21] > 5'd1) |=> (resv_exc_o && !valid_o));

    p_rot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && instr_i[31:26] == GRP_MAJOR && instr_i[5:0] == FN_D_RR
         && instr_i[10:6] == 5'd1 && amt_i[AMT_W-1:0] == '0)
        |=> (valid_o && result_o == $past(src_i)));

    p_foreign_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && instr_i[31:26] != GRP_MAJOR) |=> (!valid_o && !resv_exc_o));

endmodule

bind shift_rot_unit shift_rot_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .instr_i    (instr_i),
    .src_i      (src_i),
    .amt_i      (amt_i),
    .result_o   (result_o),
    .valid_o    (valid_o),
    .resv_exc_o (resv_exc_o)
);

// File: tb/shift_rot_unit_tb_top.sv
module shift_rot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] amt_i = '0;
    logic [63:0] result_o;
    logic        valid_o;
    logic        resv_exc_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [63:0] exp_res = '0;

    logic        q_vld [$];
    logic        q_exc [$];
    logic [63:0] q_res [$];
    string       q_tag [$];

    always #2 clk = ~clk;   // 250 MHz

    shift_rot_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue_i),
        .instr_i    (instr_i),
        .src_i      (src_i),
        .amt_i      (amt_i),
        .result_o   (result_o),
        .valid_o    (valid_o),
        .resv_exc_o (resv_exc_o)
    );

    function automatic logic [31:0] mk(input logic [5:0] major, input logic [5:0] fn,
                                       input logic [4:0] hi, input logic [4:0] sa);
        return {major, hi, 10'h2A5, sa, fn};
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [31:0] ror32(input logic [31:0] x, input int n);
        if (n == 0) return x;
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [63:0] ror64(input logic [63:0] x, input int n);
        if (n == 0) return x;
        return (x >> n) | (x << (64 - n));
    endfunction

    // kind: 0 foreign, 1 result, 2 reserved
    function automatic void model(input logic [31:0] ins, input logic [63:0] s,
                                  input logic [63:0] a, output int kind,
                                  output logic [63:0] r, output string tag);
        logic [31:0] lw;
        logic [31:0] w;
        logic [4:0]  hi;
        logic [4:0]  lo;
        int          na5;
        int          na6;
        lw   = s[31:0];
        hi   = ins[25:21];
        lo   = ins[10:6];
        na5  = int'(a[4:0]);
        na6  = int'(a[5:0]);
        kind = 1;
        r    = '0;
        w    = '0;
        tag  = "R12";
        if (ins[31:26] != 6'h00) begin
            kind = 0;
            tag  = "R11";
            return;
        end
        case (ins[5:0])
            6'h00: begin w = lw << lo; r = sx(w); tag = "R4"; end
            6'h03: begin w = $signed(lw) >>> lo; r = sx(w); tag = "R5"; end
            6'h02: begin
                if (hi == 5'd0)      begin w = lw >> lo; r = sx(w); tag = "R4"; end
                else if (hi == 5'd1) begin r = sx(ror32(lw, int'(lo))); tag = "R6"; end
                else                 begin kind = 2; tag = "R9"; end
            end
            6'h04: begin w = lw << na5; r = sx(w); tag = "R3"; end
            6'h07: begin w = $signed(lw) >>> na5; r = sx(w); tag = "R3"; end
            6'h06: begin
                if (lo == 5'd0)      begin w = lw >> na5; r = sx(w); tag = "R3"; end
                else if (lo == 5'd1) begin r = sx(ror32(lw, na5)); tag = "R6"; end
                else                 begin kind = 2; tag = "R9"; end
            end
            6'h14: begin r = s << na6; tag = "R7"; end
            6'h17: begin r = $signed(s) >>> na6; tag = "R7"; end
            6'h16: begin
                if (lo == 5'd0)      begin r = s >> na6; tag = "R7"; end
                else if (lo == 5'd1) begin r = ror64(s, na6); tag = "R7"; end
                else                 begin kind = 2; tag = "R9"; end
            end
            6'h38: begin r = s << lo; tag = "R7"; end
            6'h3B: begin r = $signed(s) >>> lo; tag = "R7"; end
            6'h3A: begin
                if (hi == 5'd0)      begin r = s >> lo; tag = "R7"; end
                else if (hi == 5'd1) begin r = ror64(s, int'(lo)); tag = "R7"; end
                else                 begin kind = 2; tag = "R9"; end
            end
            6'h3C: begin r = s << (int'(lo) + 32); tag = "R8"; end
            6'h3F: begin r = $signed(s) >>> (int'(lo) + 32); tag = "R8"; end
            6'h3E: begin
                if (hi == 5'd0)      begin r = s >> (int'(lo) + 32); tag = "R8"; end
                else if (hi == 5'd1) begin r = ror64(s, int'(lo) + 32); tag = "R8"; end
                else                 begin kind = 2; tag = "R9"; end
            end
            default: begin kind = 0; tag = "R11"; end
        endcase
    endfunction

    task automatic drive(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] a);
        int          kind;
        logic [63:0] r;
        string       tag;
        model(ins, s, a, kind, r, tag);
        if (kind == 1) exp_res = r;
        if (kind == 2) tag = {tag, "+R10"};
        @(negedge clk);
        issue_i = 1'b1;
        instr_i = ins;
        src_i   = s;
        amt_i   = a;
        q_vld.push_back(kind == 1);
        q_exc.push_back(kind == 2);
        q_res.push_back(exp_res);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input logic [31:0] ins);
        @(negedge clk);
        issue_i = 1'b0;
        instr_i = ins;
        src_i   = 64'hDEAD_BEEF_0BAD_F00D;
        amt_i   = 64'h7;
        q_vld.push_back(1'b0);
        q_exc.push_back(1'b0);
        q_res.push_back(exp_res);
        q_tag.push_back("R2");
    endtask

    // monitor: one expected item per clock edge after it was pushed
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_vld.size() > 0) begin
                logic        ev;
                logic        ee;
                logic [63:0] er;
                string       et;
                ev = q_vld.pop_front();
                ee = q_exc.pop_front();
                er = q_res.pop_front();
                et = q_tag.pop_front();
                n_checks++;
                if (valid_o !== ev || resv_exc_o !== ee || result_o !== er) begin
                    n_errors++;
                    $display("FAIL %s: got vld=%0b exc=%0b res=%h, expected vld=%0b exc=%0b res=%h",
                             et, valid_o, resv_exc_o, result_o, ev, ee, er);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] srcs [4];
        logic [4:0]  sas [5];
        logic [63:0] amts [7];
        logic [5:0]  imm_fns [6];
        logic [5:0]  rimm_fns [3];
        logic [5:0]  reg_fns [4];
        logic [5:0]  rreg_fns [2];
        logic [5:0]  foreign_fns [5];
        srcs = '{64'hF0E1_D2C3_B4A5_9687, 64'h0123_4567_89AB_CDEF,
                 64'h8000_0001_8000_0001, 64'h0000_0000_7FFF_FFFF};
        sas  = '{5'd0, 5'd1, 5'd31, 5'd13, 5'd16};
        amts = '{64'd0, 64'd1, 64'd31, 64'd32, 64'd63,
                 64'hFFFF_FFFF_FFFF_FFE1, 64'h40};
        imm_fns     = '{6'h00, 6'h03, 6'h38, 6'h3B, 6'h3C, 6'h3F};
        rimm_fns    = '{6'h02, 6'h3A, 6'h3E};
        reg_fns     = '{6'h04, 6'h07, 6'h14, 6'h17};
        rreg_fns    = '{6'h06, 6'h16};
        foreign_fns = '{6'h01, 6'h05, 6'h15, 6'h39, 6'h3D};

        // R1: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (result_o !== '0 || valid_o !== 1'b0 || resv_exc_o !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: got res=%h vld=%0b exc=%0b, expected 0 0 0",
                     result_o, valid_o, resv_exc_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (result_o !== '0 || valid_o !== 1'b0 || resv_exc_o !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: got res=%h vld=%0b exc=%0b after release, expected 0 0 0",
                     result_o, valid_o, resv_exc_o);
        end

        // immediate forms without a selector (R4 R5 R7 R8)
        foreach (imm_fns[f]) foreach (srcs[i]) foreach (sas[k])
            drive(mk(6'h00, imm_fns[f], 5'd0, sas[k]), srcs[i], 64'hFFFF);

        // immediate right forms, shift and rotate (R6 R8 R9)
        foreach (rimm_fns[f]) foreach (srcs[i]) foreach (sas[k])
            for (int sel = 0; sel < 2; sel++)
                drive(mk(6'h00, rimm_fns[f], 5'(sel), sas[k]), srcs[i], 64'h3);

        // register forms (R3 R7)
        foreach (reg_fns[f]) foreach (srcs[i]) foreach (amts[k])
            drive(mk(6'h00, reg_fns[f], 5'd9, 5'd0), srcs[i], amts[k]);

        // register right forms, shift and rotate (R3 R6 R7)
        foreach (rreg_fns[f]) foreach (srcs[i]) foreach (amts[k])
            for (int sel = 0; sel < 2; sel++)
                drive(mk(6'h00, rreg_fns[f], 5'd0, 5'(sel)), srcs[i], amts[k]);

        // R2: idle cycles carrying a valid-looking word
        idle(mk(6'h00, 6'h3E, 5'd1, 5'd7));
        idle(mk(6'h00, 6'h02, 5'd2, 5'd7));
        drive(mk(6'h00, 6'h00, 5'd0, 5'd4), 64'h1234, '0);
        idle(mk(6'h00, 6'h00, 5'd0, 5'd4));

        // R9 R10: each reserved selector right after a valid rotate
        for (int sel = 2; sel < 32; sel++) begin
            foreach (rimm_fns[f]) begin
                drive(mk(6'h00, 6'h16, 5'd0, 5'd1), srcs[sel % 4], 64'(sel));
                drive(mk(6'h00, rimm_fns[f], 5'(sel), 5'd3), srcs[(sel + 1) % 4], 64'h5);
            end
            foreach (rreg_fns[f]) begin
                drive(mk(6'h00, 6'h02, 5'd1, 5'(sel)), srcs[sel % 4], 64'h0);
                drive(mk(6'h00, rreg_fns[f], 5'd0, 5'(sel)), srcs[(sel + 2) % 4], 64'h5);
            end
        end

        // R11: outside the group
        drive(mk(6'h00, 6'h3C, 5'd0, 5'd5), 64'hA5A5_0000_FFFF_1234, '0);
        for (int m = 1; m < 64; m += 9)
            drive(mk(6'(m), 6'h02, 5'd0, 5'd4), srcs[m % 4], 64'h2);
        foreach (foreign_fns[f])
            drive(mk(6'h00, foreign_fns[f], 5'd0, 5'd4), srcs[f % 4], 64'h2);

        idle('0);
        idle('0);
        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule